// File: doc/BRIEF.md
# Responder Exit Resume Handler

This block is the per-processor controller on a non-initiating logical processor. It handles the platform-wide broadcast that tears down a protected launch environment. When the exit broadcast arrives, the block silences and clears that event and resets the monitor/wait tracking. It re-opens the launch event and returns an acknowledge to the initiator. If the processor is running under virtualization at that moment, the exit is an illegal event: the block raises shutdown with a fixed code instead.

After acknowledging, the block waits for the initiator's continue broadcast. It then re-enables the four external pin events and publishes a one-hot resume mode that tells the rest of the core how to pick up execution. The choice depends on what the processor was doing when the exit message was recognized. A processor that was never woken from the launch sleep is sent through a soft-reset style initialization to wait for a startup interrupt, and only on that path are the flags altered. The resume mode stays on its output until the core clears it.

Top module: `rsp_exit_resume`

## Requirements
- R1: With the block idle and virtualization inactive, an exit message sampled at a clock edge makes `ack_o`, `evt_off_o`, `mon_clr_o` and `enter_unmask_o` high for exactly the one cycle after that edge.
- R2: With virtualization active when the exit message is sampled, `shutdown_o` pulses for one cycle and no acknowledge is sent. `shut_code_o` holds the illegal-event code (parameter, default 8'h1D) from then on, and every later message is ignored until reset.
- R3: `pin_unmask_o` becomes 4'b1111 (bit 0 SMI, bit 1 INIT, bit 2 A20M, bit 3 NMI) for one cycle, exactly one cycle after the continue message is sampled while awaiting it, and is zero at all other times.
- R4: Prior state codes 0 (normal) and 5 to 7 (unassigned) yield resume mode bit 0, restart of the pending instruction.
- R5: Prior state code 1 (halted) yields resume mode bit 1, re-enter halt.
- R6: Prior state code 2 (monitor-wait) yields resume mode bit 2, leave the wait and fall through to the next instruction.
- R7: Prior state code 3 (mid-string) yields resume mode bit 3, continue the string instruction at the recognized iteration.
- R8: Prior state code 4 (launch sleep) yields resume mode bit 4. In the same cycle as the pin unmask, `bsp_clr_o`, `sipi_pend_clr_o`, `init_req_o` and `sipi_unmask_o` each pulse once.
- R9: `flags_mod_o` pulses only on the launch-sleep path, together with the pin unmask, and never on other paths.
- R10: `resume_mode_o` is always one-hot or zero. It is loaded when the continue message completes and held until `mode_clr_i` is high at an edge with no completion, after which it reads zero.
- R11: The prior state is captured at the exit message. Later changes to it, a continue message while idle, and an exit message while awaiting continue all have no effect on any output.
- R12: While and after a synchronous reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exit_msg_i | input | 1 | Exit broadcast received |
| cont_msg_i | input | 1 | Continue broadcast received |
| virt_active_i | input | 1 | Virtualization operation active |
| prior_i | input | 3 | Prior execution state code |
| mode_clr_i | input | 1 | Clears the held resume mode |
| ack_o | output | 1 | Acknowledge message pulse |
| evt_off_o | output | 1 | Mask-and-clear exit event pulse |
| mon_clr_o | output | 1 | Monitor tracking clear pulse |
| enter_unmask_o | output | 1 | Launch event unmask pulse |
| shutdown_o | output | 1 | Shutdown request pulse |
| shut_code_o | output | 8 | Shutdown reason code |
| pin_unmask_o | output | 4 | Pin event unmask pulses |
| bsp_clr_o | output | 1 | Clear bootstrap-processor bit pulse |
| sipi_pend_clr_o | output | 1 | Clear pending startup state pulse |
| init_req_o | output | 1 | Soft-reset style initialization request |
| sipi_unmask_o | output | 1 | Startup interrupt unmask pulse |
| flags_mod_o | output | 1 | Flags are rewritten pulse |
| resume_mode_o | output | 5 | One-hot held resume mode |

## Verification
The bench changes the prior state code immediately after the exit message. A design that sampled it late would publish the wrong resume mode. It sends stray exit messages while awaiting continue and stray continue messages while idle: a design that re-armed would acknowledge twice or unmask pins early. The unassigned codes 5 to 7 must fall back to restart, and a decoder that missed them would leave the mode zero or multi-hot. The virtualization case must end in a sticky shutdown with no acknowledge. The sleep-only pulses and the flags pulse are checked to stay low on every other path.

// File: rtl/rsp_exit_pkg.sv
package rsp_exit_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHUT} rsp_state_e;
  localparam int MD_RESTART = 0;
  localparam int MD_HALT    = 1;
  localparam int MD_FALL    = 2;
  localparam int MD_STRING  = 3;
  localparam int MD_SLEEP   = 4;
  localparam int NUM_MODES  = 5;
endpackage

// File: rtl/rsp_mode_decode.sv
module rsp_mode_decode #(
  parameter int PRIOR_W = 3,
  parameter int MODES   = 5
) (
  input  logic [PRIOR_W-1:0] prior_i,
  output logic [MODES-1:0]   mode_o
);
  logic [MODES-1:0] hit;
  assign hit[0] = 1'b0;
  for (genvar g = 1; g < MODES; g++) begin : g_hit
    assign hit[g] = (prior_i == PRIOR_W'(g));
  end
  always_comb begin
    mode_o    = hit;
    mode_o[0] = ~|hit;
  end
endmodule

// File: rtl/rsp_mode_hold.sv
module rsp_mode_hold #(
  parameter int MODES = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [MODES-1:0] val_i,
  input  logic             clr_i,
  output logic [MODES-1:0] mode_o
);
  always_ff @(posedge clk) begin
    if (rst)        mode_o <= '0;
    else if (set_i) mode_o <= val_i;
    else if (clr_i) mode_o <= '0;
  end

  p_mode_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mode_o));
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(mode_o));
  p_mode_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (!set_i && clr_i) |=> (mode_o == '0));
endmodule

// File: rtl/rsp_exit_fsm.sv
module rsp_exit_fsm
  import rsp_exit_pkg::*;
#(
  parameter int          PRIOR_W   = 3,
  parameter int          PIN_W     = 4,
  parameter int          CODE_W    = 8,
  parameter logic [7:0]  SHUT_CODE = 8'h1D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exit_msg_i,
  input  logic               cont_msg_i,
  input  logic               virt_active_i,
  input  logic [PRIOR_W-1:0] prior_i,
  input  logic               sleep_path_i,
  output logic [PRIOR_W-1:0] prior_q_o,
  output logic               finish_o,
  output logic               ack_o,
  output logic               evt_off_o,
  output logic               mon_clr_o,
  output logic               enter_unmask_o,
  output logic               shutdown_o,
  output logic [CODE_W-1:0]  shut_code_o,
  output logic [PIN_W-1:0]   pin_unmask_o,
  output logic               bsp_clr_o,
  output logic               sipi_pend_clr_o,
  output logic               init_req_o,
  output logic               sipi_unmask_o,
  output logic               flags_mod_o
);
  rsp_state_e state;

  assign finish_o = (state == ST_WAIT) && cont_msg_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      prior_q_o       <= '0;
      ack_o           <= 1'b0;
      evt_off_o       <= 1'b0;
      mon_clr_o       <= 1'b0;
      enter_unmask_o  <= 1'b0;
      shutdown_o      <= 1'b0;
      shut_code_o     <= '0;
      pin_unmask_o    <= '0;
      bsp_clr_o       <= 1'b0;
      sipi_pend_clr_o <= 1'b0;
      init_req_o      <= 1'b0;
      sipi_unmask_o   <= 1'b0;
      flags_mod_o     <= 1'b0;
    end else begin
      ack_o           <= 1'b0;
      evt_off_o       <= 1'b0;
      mon_clr_o       <= 1'b0;
      enter_unmask_o  <= 1'b0;
      shutdown_o      <= 1'b0;
      pin_unmask_o    <= '0;
      bsp_clr_o       <= 1'b0;
      sipi_pend_clr_o <= 1'b0;
      init_req_o      <= 1'b0;
      sipi_unmask_o   <= 1'b0;
      flags_mod_o     <= 1'b0;
      case (state)
        ST_IDLE: if (exit_msg_i) begin
          prior_q_o <= prior_i;
          if (virt_active_i) begin
            shutdown_o  <= 1'b1;
            shut_code_o <= CODE_W'(SHUT_CODE);
            state       <= ST_SHUT;
          end else begin
            ack_o          <= 1'b1;
            evt_off_o      <= 1'b1;
            mon_clr_o      <= 1'b1;
            enter_unmask_o <= 1'b1;
            state          <= ST_WAIT;
          end
        end
        ST_WAIT: if (cont_msg_i) begin
          pin_unmask_o <= '1;
          if (sleep_path_i) begin
            bsp_clr_o       <= 1'b1;
            sipi_pend_clr_o <= 1'b1;
            init_req_o      <= 1'b1;
            sipi_unmask_o   <= 1'b1;
            flags_mod_o     <= 1'b1;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_SHUT;
      endcase
    end
  end

  p_ack_after_exit_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && exit_msg_i && !virt_active_i) |=> ack_o);
  p_ack_single_r1: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
  p_shut_no_ack_r2: assert property (@(posedge clk) disable iff (rst)
    shutdown_o |-> !ack_o);
  p_shut_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHUT) |=> (state == ST_SHUT && pin_unmask_o == '0 && !ack_o));
  p_unmask_after_cont_r3: assert property (@(posedge clk) disable iff (rst)
    (pin_unmask_o != '0) |-> $past(cont_msg_i));
  p_no_rearm_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !cont_msg_i) |=> (!ack_o && pin_unmask_o == '0));
endmodule

// File: rtl/rsp_exit_resume.sv
module rsp_exit_resume
  import rsp_exit_pkg::*;
#(
  parameter int         PRIOR_W   = 3,
  parameter int         PIN_W     = 4,
  parameter int         CODE_W    = 8,
  parameter logic [7:0] SHUT_CODE = 8'h1D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exit_msg_i,
  input  logic               cont_msg_i,
  input  logic               virt_active_i,
  input  logic [PRIOR_W-1:0] prior_i,
  input  logic               mode_clr_i,
  output logic               ack_o,
  output logic               evt_off_o,
  output logic               mon_clr_o,
  output logic               enter_unmask_o,
  output logic               shutdown_o,
  output logic [CODE_W-1:0]  shut_code_o,
  output logic [PIN_W-1:0]   pin_unmask_o,
  output logic               bsp_clr_o,
  output logic               sipi_pend_clr_o,
  output logic               init_req_o,
  output logic               sipi_unmask_o,
  output logic               flags_mod_o,
  output logic [NUM_MODES-1:0] resume_mode_o
);
  logic [PRIOR_W-1:0]   prior_q;
  logic [NUM_MODES-1:0] mode_dec;
  logic                 finish;

  rsp_mode_decode #(.PRIOR_W(PRIOR_W), .MODES(NUM_MODES)) u_dec (
    .prior_i (prior_q),
    .mode_o  (mode_dec)
  );

  rsp_exit_fsm #(.PRIOR_W(PRIOR_W), .PIN_W(PIN_W), .CODE_W(CODE_W),
                 .SHUT_CODE(SHUT_CODE)) u_fsm (
    .clk             (clk),
    .rst             (rst),
    .exit_msg_i      (exit_msg_i),
    .cont_msg_i      (cont_msg_i),
    .virt_active_i   (virt_active_i),
    .prior_i         (prior_i),
    .sleep_path_i    (mode_dec[MD_SLEEP]),
    .prior_q_o       (prior_q),
    .finish_o        (finish),
    .ack_o           (ack_o),
    .evt_off_o       (evt_off_o),
    .mon_clr_o       (mon_clr_o),
    .enter_unmask_o  (enter_unmask_o),
    .shutdown_o      (shutdown_o),
    .shut_code_o     (shut_code_o),
    .pin_unmask_o    (pin_unmask_o),
    .bsp_clr_o       (bsp_clr_o),
    .sipi_pend_clr_o (sipi_pend_clr_o),
    .init_req_o      (init_req_o),
    .sipi_unmask_o   (sipi_unmask_o),
    .flags_mod_o     (flags_mod_o)
  );

  rsp_mode_hold #(.MODES(NUM_MODES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .set_i  (finish),
    .val_i  (mode_dec),
    .clr_i  (mode_clr_i),
    .mode_o (resume_mode_o)
  );

  p_sleep_bundle_r8: assert property (@(posedge clk) disable iff (rst)
    bsp_clr_o |-> (sipi_pend_clr_o && init_req_o && sipi_unmask_o &&
                   resume_mode_o[MD_SLEEP] && pin_unmask_o != '0));
  p_flags_sleep_only_r9: assert property (@(posedge clk) disable iff (rst)
    flags_mod_o |-> (resume_mode_o[MD_SLEEP] && pin_unmask_o != '0));
  p_mode_with_unmask_r4: assert property (@(posedge clk) disable iff (rst)
    (pin_unmask_o != '0) |-> $onehot(resume_mode_o));
endmodule

// File: tb/test_rsp_exit_resume.sv
module test_rsp_exit_resume;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exit_msg = 1'b0, cont_msg = 1'b0, virt = 1'b0, mode_clr = 1'b0;
  logic [2:0] prior = '0;
  logic ack, evt_off, mon_clr, enter_unmask, shutdown;
  logic [7:0] shut_code;
  logic [3:0] pin_unmask;
  logic bsp_clr, sipi_pend_clr, init_req, sipi_unmask, flags_mod;
  logic [4:0] resume_mode;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rsp_exit_resume i_rsp_exit_resume (
    .clk(clk), .rst(rst), .exit_msg_i(exit_msg), .cont_msg_i(cont_msg),
    .virt_active_i(virt), .prior_i(prior), .mode_clr_i(mode_clr),
    .ack_o(ack), .evt_off_o(evt_off), .mon_clr_o(mon_clr),
    .enter_unmask_o(enter_unmask), .shutdown_o(shutdown),
    .shut_code_o(shut_code), .pin_unmask_o(pin_unmask),
    .bsp_clr_o(bsp_clr), .sipi_pend_clr_o(sipi_pend_clr),
    .init_req_o(init_req), .sipi_unmask_o(sipi_unmask),
    .flags_mod_o(flags_mod), .resume_mode_o(resume_mode)
  );

  function automatic logic [4:0] exp_mode(input logic [2:0] p);
    if (p >= 3'd1 && p <= 3'd4) return 5'b1 << p;
    return 5'b00001;
  endfunction

  function automatic string req_of(input logic [2:0] p);
    case (p)
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic all_zero(input string req);
    chk(req, {ack, evt_off, mon_clr, enter_unmask, shutdown, bsp_clr, sipi_pend_clr,
              init_req, sipi_unmask, flags_mod}, 0);
    chk(req, {shut_code, pin_unmask, resume_mode}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; exit_msg = 0; cont_msg = 0; virt = 0; mode_clr = 0;
    tick(); tick();
    all_zero("R12 in reset");
    @(negedge clk); rst = 1'b0;
    tick();
    all_zero("R12 after reset");
  endtask

  task automatic run_exit(input logic [2:0] pr, input bit vt, input int gap, input bit clr);
    logic [4:0] em;
    em = exp_mode(pr);
    @(negedge clk); exit_msg = 1; prior = pr; virt = vt;
    tick();
    if (vt) begin
      chk("R2 shutdown pulse", shutdown, 1);
      chk("R2 no ack", ack, 0);
      chk("R2 code", shut_code, 8'h1D);
      @(negedge clk); exit_msg = 0; virt = 0; prior = 3'($urandom);
      tick();
      chk("R2 shutdown one cycle", shutdown, 0);
      @(negedge clk); exit_msg = 1; cont_msg = 1;
      tick();
      chk("R2 ignores later msgs ack", ack, 0);
      chk("R2 ignores later msgs pins", pin_unmask, 0);
      chk("R2 code held", shut_code, 8'h1D);
      @(negedge clk); exit_msg = 0; cont_msg = 0;
      do_reset();
      return;
    end
    chk("R1 ack", ack, 1);
    chk("R1 event off", evt_off, 1);
    chk("R1 monitor clear", mon_clr, 1);
    chk("R1 enter unmask", enter_unmask, 1);
    chk("R3 no early unmask", pin_unmask, 0);
    @(negedge clk); exit_msg = 0; virt = 0; prior = 3'($urandom);
    tick();
    chk("R1 single pulse", {ack, evt_off, mon_clr, enter_unmask}, 0);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk); exit_msg = 1'($urandom); prior = 3'($urandom);
      tick();
      chk("R11 stray exit no ack", ack, 0);
      chk("R3 no unmask while waiting", pin_unmask, 0);
    end
    @(negedge clk); exit_msg = 0; cont_msg = 1;
    tick();
    chk("R3 pin unmask", pin_unmask, 4'hF);
    chk({req_of(pr), " resume mode"}, resume_mode, em);
    chk("R8 sleep bundle", {bsp_clr, sipi_pend_clr, init_req, sipi_unmask},
        (pr == 3'd4) ? 4'hF : 4'h0);
    chk("R9 flags", flags_mod, pr == 3'd4);
    @(negedge clk); cont_msg = 0;
    tick();
    chk("R3 unmask one cycle", pin_unmask, 0);
    chk("R8 pulses one cycle", {bsp_clr, sipi_pend_clr, init_req, sipi_unmask, flags_mod}, 0);
    chk("R10 mode held", resume_mode, em);
    @(negedge clk); cont_msg = 1;
    tick();
    chk("R11 stray continue pins", pin_unmask, 0);
    chk("R11 stray continue mode", resume_mode, em);
    @(negedge clk); cont_msg = 0;
    if (clr) begin
      @(negedge clk); mode_clr = 1;
      tick();
      chk("R10 mode cleared", resume_mode, 0);
      @(negedge clk); mode_clr = 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC7));
    do_reset();
    @(negedge clk); cont_msg = 1;
    tick();
    chk("R11 continue while idle", pin_unmask, 0);
    chk("R11 continue while idle mode", resume_mode, 0);
    @(negedge clk); cont_msg = 0;
    for (int p = 0; p < 8; p++) run_exit(3'(p), 1'b0, 2, 1'b1);
    run_exit(3'd1, 1'b0, 0, 1'b0);
    run_exit(3'd4, 1'b0, 3, 1'b0);
    run_exit(3'd4, 1'b1, 0, 1'b0);
    for (int k = 0; k < 60; k++)
      run_exit(3'($urandom), ($urandom % 8) == 0, int'($urandom % 4), 1'($urandom));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule